// File: doc/BRIEF.md
# Macroblock Coding Mode Decision Unit

The unit makes the per-macroblock coding choices of a video encoder: inter or intra coding, whether the loop filter is applied, and which quantiser goes with the macroblock. It does this from the best-fit mean absolute error (MAE), the variance of the current block and a motion-vector flag. One pulse on `mbStart` samples these inputs. One clock later the unit presents a registered status word, the quantiser and a coding enable.

A host steers the choices through an 8-bit control word. The per-macroblock overrides are force mode, force filter and freeze macroblock. They pass through a two-stage pipeline that advances on each macroblock pulse. The frame-wide bits are fast refresh and drop frame. They are captured only on a frame start pulse. A built-in periodic refresh controller forces an intra macroblock after a run of inter macroblocks, and the host can switch it off.

Top module: `mbModeDecide`

## Requirements
- R1: With no override active, a macroblock is inter coded (status bit0 = 1) when `mae[13:6]` is below `varThresh`. Otherwise it is inter coded only when `mae < blkVar`, and intra coded (bit0 = 0) when it is not.
- R2: Control bit0 = 1 replaces the automatic inter/intra choice. Control bit1 = 1 then forces intra and bit1 = 0 forces inter.
- R3: The filter flag (status bit3) follows motion-compensation use for inter macroblocks. Control bit2 = 1 replaces it with control bit3. Intra macroblocks are never filtered.
- R4: Control bit4 = 1 freezes the macroblock: `codeEn` = 0, status bit4 = 1, bit0 = 1, bits 1 and 3 = 0.
- R5: Control bits 4:0 written before macroblock pulse k first govern the decision of macroblock k+2. They stay in force until they are rewritten.
- R6: Control bits 6:5 act only from the next `frameStart` pulse, including a macroblock pulse in the same cycle. They then hold for every later frame until cleared.
- R7: Fast refresh (control bit5, shown in status bit5) makes every coded macroblock intra. It outranks the force-mode bits.
- R8: Drop frame (control bit6, shown in status bit6) outranks all else: `codeEn` = 0, status bit4 = 0, bit0 = 1, bits 1 and 3 = 0. Freeze outranks everything except drop frame.
- R9: After `REFRESH_MBS` consecutive coded inter macroblocks, the next macroblock without a force-mode override is intra. Control bit7 = 1 disables this rule.
- R10: `quantOut` is `{intraQ,1'b0}` for intra macroblocks when `sepQuant` = 1. Otherwise it is `{interQ,1'b0}`.
- R11: Status bit1 (motion compensation used) is set only for inter macroblocks with `mvNonZero` = 1 and `mcDisable` = 0.
- R12: After reset all outputs are 0 and every override is cleared. `decValid` pulses exactly one cycle after each `mbStart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Frame start pulse |
| mbStart | input | 1 | Macroblock start pulse; samples the inputs |
| ctrlWe | input | 1 | Host control word write strobe |
| ctrlWord | input | 8 | Host control word |
| mcDisable | input | 1 | Motion compensation disabled |
| sepQuant | input | 1 | Use a separate intra quantiser |
| varThresh | input | 8 | MAE threshold |
| interQ | input | 5 | Inter quantiser, in steps of two |
| intraQ | input | 5 | Intra quantiser, in steps of two |
| mae | input | 14 | Best-fit MAE |
| blkVar | input | 14 | Current block variance |
| mvNonZero | input | 1 | Best-fit motion vector is non-zero |
| decValid | output | 1 | Decision valid pulse |
| decWord | output | 8 | Status word |
| quantOut | output | 6 | Selected quantiser |
| codeEn | output | 1 | Macroblock is coded |

## Verification
A wrong stage in the override pipeline shows up as a forced decision that lands one macroblock early or late. It is caught on the second or third `decValid` after a control write. A frame latch that is stale or captured at the wrong moment gives a wrong status bit5 or bit6 on the first macroblock of a frame. A wrong refresh count moves the forced intra macroblock within a run of inter ones. The scoreboard predicts each status word and quantiser from the control writes alone, so any such shift is seen on the very pulse where it first matters.

// File: rtl/mbDecPkg.sv
package mbDecPkg;
  localparam int OVR_DELAY = 2;
  localparam int OVR_W     = 5;

  typedef struct packed {
    logic take;
    logic skip;
    logic fastUpd;
    logic fixMb;
    logic filtOn;
    logic filtOvr;
    logic modeIntra;
    logic modeOvr;
    logic refreshIntra;
  } mbStrobe_t;
endpackage

// File: rtl/mbDecCtrl.sv
module mbDecCtrl
  import mbDecPkg::*;
#(
  parameter int REFRESH_MBS = 132
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            frameStart,
  input  logic            mbStart,
  input  logic            ctrlWe,
  input  logic [7:0]      ctrlWord,
  input  logic            resValid,
  input  logic            resIntra,
  input  logic            resCoded,
  output mbStrobe_t       strb
);
  localparam int CNT_W = $clog2(REFRESH_MBS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(REFRESH_MBS);

  logic [7:0]       ctrlReg;
  logic [OVR_W-1:0] ovrStg [OVR_DELAY];
  logic [1:0]       frameReg;
  logic [1:0]       frameNow;
  logic [CNT_W-1:0] refCnt;
  logic [OVR_W-1:0] ovrUse;

  always_ff @(posedge clk) begin
    if (!rstN) ctrlReg <= '0;
    else if (ctrlWe) ctrlReg <= ctrlWord;
  end

  generate
    for (genvar s = 0; s < OVR_DELAY; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rstN) ovrStg[s] <= '0;
        else if (mbStart) begin
          if (s == 0) ovrStg[s] <= ctrlReg[OVR_W-1:0];
          else        ovrStg[s] <= ovrStg[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) frameReg <= '0;
    else if (frameStart) frameReg <= ctrlReg[6:5];
  end

  always_ff @(posedge clk) begin
    if (!rstN) refCnt <= '0;
    else if (resValid && resCoded) begin
      if (resIntra) refCnt <= '0;
      else if (refCnt < CNT_MAX) refCnt <= refCnt + 1'b1;
    end
  end

  assign frameNow = frameStart ? ctrlReg[6:5] : frameReg;
  assign ovrUse   = ovrStg[OVR_DELAY-1];

  always_comb begin
    strb.take         = mbStart;
    strb.skip         = frameNow[1];
    strb.fastUpd      = frameNow[0];
    strb.fixMb        = ovrUse[4];
    strb.filtOn       = ovrUse[3];
    strb.filtOvr      = ovrUse[2];
    strb.modeIntra    = ovrUse[1];
    strb.modeOvr      = ovrUse[0];
    strb.refreshIntra = (refCnt >= CNT_MAX) && !ctrlReg[7];
  end

  // R5
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mbStart |=> $stable(ovrUse));
  // R6
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(frameReg));
  // R9
  refresh_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    refCnt <= CNT_MAX);
endmodule

// File: rtl/mbDecPath.sv
module mbDecPath
  import mbDecPkg::*;
#(
  parameter int MAE_W = 14,
  parameter int THR_W = 8,
  parameter int Q_W   = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  mbStrobe_t        strb,
  input  logic             mcDisable,
  input  logic             sepQuant,
  input  logic [THR_W-1:0] varThresh,
  input  logic [Q_W-1:0]   interQ,
  input  logic [Q_W-1:0]   intraQ,
  input  logic [MAE_W-1:0] mae,
  input  logic [MAE_W-1:0] blkVar,
  input  logic             mvNonZero,
  output logic             decValid,
  output logic [7:0]       decWord,
  output logic [Q_W:0]     quantOut,
  output logic             codeEn
);
  logic [THR_W-1:0] maeHi;
  logic autoInter, isIntra, mcUsed, filtUsed, notCoded;
  logic [7:0] wordNext;
  logic [Q_W:0] quantNext;

  assign maeHi     = mae[MAE_W-1 -: THR_W];
  assign autoInter = (maeHi < varThresh) || (mae < blkVar);
  assign notCoded  = strb.skip || strb.fixMb;

  always_comb begin
    if (strb.fastUpd)      isIntra = 1'b1;
    else if (strb.modeOvr) isIntra = strb.modeIntra;
    else                   isIntra = strb.refreshIntra || !autoInter;
    mcUsed   = !notCoded && !isIntra && mvNonZero && !mcDisable;
    filtUsed = !notCoded && !isIntra && (strb.filtOvr ? strb.filtOn : mcUsed);
    wordNext = '0;
    wordNext[0] = notCoded || !isIntra;
    wordNext[1] = mcUsed;
    wordNext[3] = filtUsed;
    wordNext[4] = strb.fixMb && !strb.skip;
    wordNext[5] = strb.fastUpd;
    wordNext[6] = strb.skip;
    quantNext = (!notCoded && isIntra && sepQuant) ? {intraQ, 1'b0} : {interQ, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid <= 1'b0;
      decWord  <= '0;
      quantOut <= '0;
      codeEn   <= 1'b0;
    end else begin
      decValid <= strb.take;
      if (strb.take) begin
        decWord  <= wordNext;
        quantOut <= quantNext;
        codeEn   <= !notCoded;
      end
    end
  end

  // R8
  skip_nocode_chk: assert property (@(posedge clk) disable iff (!rstN)
    decValid && decWord[6] |-> !codeEn && !decWord[4]);
  // R4
  fix_nocode_chk: assert property (@(posedge clk) disable iff (!rstN)
    decValid && decWord[4] |-> !codeEn);
  // R3
  intra_nofilt_chk: assert property (@(posedge clk) disable iff (!rstN)
    decValid && !decWord[0] |-> !decWord[3] && !decWord[1]);
  // R7
  fastupd_intra_chk: assert property (@(posedge clk) disable iff (!rstN)
    decValid && codeEn && decWord[5] |-> !decWord[0]);
endmodule

// File: rtl/mbModeDecide.sv
module mbModeDecide
  import mbDecPkg::*;
#(
  parameter int REFRESH_MBS = 132
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStart,
  input  logic        mbStart,
  input  logic        ctrlWe,
  input  logic [7:0]  ctrlWord,
  input  logic        mcDisable,
  input  logic        sepQuant,
  input  logic [7:0]  varThresh,
  input  logic [4:0]  interQ,
  input  logic [4:0]  intraQ,
  input  logic [13:0] mae,
  input  logic [13:0] blkVar,
  input  logic        mvNonZero,
  output logic        decValid,
  output logic [7:0]  decWord,
  output logic [5:0]  quantOut,
  output logic        codeEn
);
  mbStrobe_t strb;

  mbDecCtrl #(.REFRESH_MBS(REFRESH_MBS)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .mbStart(mbStart),
    .ctrlWe(ctrlWe), .ctrlWord(ctrlWord),
    .resValid(decValid), .resIntra(!decWord[0]), .resCoded(codeEn),
    .strb(strb)
  );

  mbDecPath #(.MAE_W(14), .THR_W(8), .Q_W(5)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .mcDisable(mcDisable),
    .sepQuant(sepQuant), .varThresh(varThresh), .interQ(interQ),
    .intraQ(intraQ), .mae(mae), .blkVar(blkVar), .mvNonZero(mvNonZero),
    .decValid(decValid), .decWord(decWord), .quantOut(quantOut),
    .codeEn(codeEn)
  );

  // R12
  valid_after_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    mbStart |=> decValid);
  // R12
  valid_only_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    decValid |-> $past(mbStart));
  // R11
  mc_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    decValid && $past(mcDisable) |-> !decWord[1]);
endmodule

// File: tb/test_mbModeDecide.sv
`timescale 1ns/1ps
module test_mbModeDecide;
  localparam int LIM = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic frameStart = 0, mbStart = 0, ctrlWe = 0;
  logic [7:0] ctrlWord = '0;
  logic mcDisable = 0, sepQuant = 0;
  logic [7:0] varThresh = 8'd8;
  logic [4:0] interQ = 5'd3, intraQ = 5'd9;
  logic [13:0] mae = '0, blkVar = '0;
  logic mvNonZero = 0;
  logic decValid, codeEn;
  logic [7:0] decWord;
  logic [5:0] quantOut;

  always #4 clk = ~clk;

  mbModeDecide #(.REFRESH_MBS(LIM)) i_mbModeDecide (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .mbStart(mbStart),
    .ctrlWe(ctrlWe), .ctrlWord(ctrlWord), .mcDisable(mcDisable),
    .sepQuant(sepQuant), .varThresh(varThresh), .interQ(interQ),
    .intraQ(intraQ), .mae(mae), .blkVar(blkVar), .mvNonZero(mvNonZero),
    .decValid(decValid), .decWord(decWord), .quantOut(quantOut),
    .codeEn(codeEn)
  );

  typedef struct {
    logic [7:0] w;
    logic [5:0] q;
    logic       c;
    string      tag;
  } exp_t;
  exp_t sbQ[$];

  int nChk = 0, nFail = 0;
  logic [7:0] hostCtrl = '0;
  logic [4:0] s1 = '0, s2 = '0;
  logic [1:0] frm = '0;
  int refCnt = 0;

  task automatic hostWrite(input logic [7:0] v);
    @(negedge clk);
    ctrlWe = 1'b1; ctrlWord = v;
    @(negedge clk);
    ctrlWe = 1'b0;
    hostCtrl = v;
  endtask

  // Reference from the requirements: overrides take two pulses, frame bits latch on frameStart
  task automatic doMb(input bit fs, input logic [13:0] m, input logic [13:0] v,
                      input bit mv, input string tag);
    exp_t e;
    bit intra, notc, inter, mc;
    @(negedge clk);
    if (fs) frm = hostCtrl[6:5];
    notc = frm[1] || s2[4];
    if (frm[0]) intra = 1;
    else if (s2[0]) intra = s2[1];
    else intra = ((refCnt >= LIM) && !hostCtrl[7]) ||
                 !((m[13:6] < varThresh) || (m < v));
    inter = !notc && !intra;
    mc = inter && mv && !mcDisable;
    e.w = '0;
    e.w[0] = notc || !intra;
    e.w[1] = mc;
    e.w[3] = inter && (s2[2] ? s2[3] : mc);
    e.w[4] = s2[4] && !frm[1];
    e.w[5] = frm[0];
    e.w[6] = frm[1];
    e.q = (!notc && intra && sepQuant) ? {intraQ, 1'b0} : {interQ, 1'b0};
    e.c = !notc;
    e.tag = tag;
    if (!notc) begin
      if (intra) refCnt = 0;
      else if (refCnt < LIM) refCnt++;
    end
    s2 = s1; s1 = hostCtrl[4:0];
    sbQ.push_back(e);
    frameStart = fs; mbStart = 1'b1; mae = m; blkVar = v; mvNonZero = mv;
    @(negedge clk);
    frameStart = 0; mbStart = 0;
    @(negedge clk);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rstN && decValid) begin
      exp_t e;
      nChk++;
      if (sbQ.size() == 0) begin
        nFail++;
        $display("FAIL R12 unexpected decValid: actual word %h expected none", decWord);
      end else begin
        e = sbQ.pop_front();
        if (decWord !== e.w || quantOut !== e.q || codeEn !== e.c) begin
          nFail++;
          $display("FAIL %s: actual word %h q %0d code %b, expected word %h q %0d code %b",
                   e.tag, decWord, quantOut, codeEn, e.w, e.q, e.c);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    nFail++; nChk++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("  %0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    nChk++; // R12 reset state
    if (decValid !== 0 || decWord !== 0 || quantOut !== 0 || codeEn !== 0) begin
      nFail++;
      $display("FAIL R12 reset: actual %b %h %h %b expected all zero",
               decValid, decWord, quantOut, codeEn);
    end
    // R12 cleared overrides: first pulses are automatic
    doMb(0, 14'h0300, 14'h0400, 1, "R12 first mb");
    hostWrite(8'h80); // refresh off
    // R1 automatic rule
    doMb(0, 14'h0100, 14'h0000, 0, "R1 below threshold");
    doMb(0, 14'h0300, 14'h0400, 0, "R1 mae<var");
    doMb(0, 14'h0300, 14'h0200, 0, "R1 mae>=var intra");
    doMb(0, 14'h0200, 14'h0200, 1, "R1 equal at threshold");
    doMb(0, 14'h0100, 14'h0000, 1, "R11 R3 mc used and filtered");
    // R2 / R5 forced intra
    hostWrite(8'h83);
    doMb(0, 14'h0100, 14'h0000, 0, "R5 delay one");
    doMb(0, 14'h0100, 14'h0000, 0, "R5 delay two");
    doMb(0, 14'h0100, 14'h0000, 0, "R2 forced intra");
    doMb(0, 14'h0080, 14'h0000, 0, "R5 persists");
    hostWrite(8'h81);
    doMb(0, 14'h3F00, 14'h0100, 1, "R2 pipe");
    doMb(0, 14'h3F00, 14'h0100, 1, "R2 pipe");
    doMb(0, 14'h3F00, 14'h0100, 1, "R2 forced inter");
    // R3 filter override
    hostWrite(8'h8C);
    doMb(0, 14'h0100, 14'h0000, 0, "R3 pipe");
    doMb(0, 14'h0100, 14'h0000, 0, "R3 pipe");
    doMb(0, 14'h0100, 14'h0000, 0, "R3 forced filter on");
    hostWrite(8'h84);
    doMb(0, 14'h0100, 14'h0000, 1, "R3 pipe");
    doMb(0, 14'h0100, 14'h0000, 1, "R3 pipe");
    doMb(0, 14'h0100, 14'h0000, 1, "R3 forced filter off");
    doMb(0, 14'h3F00, 14'h0000, 1, "R3 intra not filtered");
    // R4 freeze
    hostWrite(8'h90);
    doMb(0, 14'h0100, 14'h0000, 1, "R4 pipe");
    doMb(0, 14'h0100, 14'h0000, 1, "R4 pipe");
    doMb(0, 14'h0100, 14'h0000, 1, "R4 freeze");
    hostWrite(8'h80);
    doMb(0, 14'h0100, 14'h0000, 1, "R4 release pipe");
    doMb(0, 14'h0100, 14'h0000, 1, "R4 release pipe");
    // R6 / R7 fast refresh
    hostWrite(8'hA0);
    doMb(0, 14'h0100, 14'h0000, 0, "R6 no frame start yet");
    doMb(1, 14'h0100, 14'h0000, 0, "R7 fast refresh intra");
    doMb(0, 14'h0100, 14'h0000, 0, "R6 held in frame");
    doMb(1, 14'h0100, 14'h0000, 0, "R6 next frame");
    // R10 separate quantiser
    sepQuant = 1;
    doMb(0, 14'h0100, 14'h0000, 0, "R10 intra quant");
    // R8 drop frame outranks freeze
    hostWrite(8'hD0);
    doMb(0, 14'h0100, 14'h0000, 0, "R8 pipe");
    doMb(1, 14'h0100, 14'h0000, 0, "R8 skip");
    doMb(0, 14'h0100, 14'h0000, 0, "R8 skip over freeze");
    hostWrite(8'h80);
    doMb(1, 14'h0100, 14'h0000, 0, "R6 cleared at frame");
    doMb(0, 14'h3F00, 14'h0000, 0, "R10 intra quant sep");
    sepQuant = 0;
    doMb(0, 14'h3F00, 14'h0000, 0, "R10 common quant");
    // R11 mc disabled
    mcDisable = 1;
    doMb(0, 14'h0100, 14'h0000, 1, "R11 mc disabled");
    mcDisable = 0;
    // R9 periodic refresh
    hostWrite(8'h00);
    for (int i = 0; i < 7; i++)
      doMb(0, 14'h0100, 14'h0000, 0, "R9 refresh run");
    hostWrite(8'h80);
    for (int i = 0; i < 7; i++)
      doMb(0, 14'h0100, 14'h0000, 0, "R9 refresh disabled");
    repeat (4) @(negedge clk);
    if (sbQ.size() != 0) begin
      nChk++; nFail++;
      $display("FAIL R12 missing decValid: actual %0d left expected 0", sbQ.size());
    end
    $display("  %0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule